// File: doc/BRIEF.md
# Control-Pin Enable, Dimming-Mode Select and Duty Meter

This block watches a single multi-purpose control input and turns its waveform into four decisions: whether the driver is powered up, which dimming scheme is in force, when the brightness setting must fall back to its default, and, under pulse-width dimming, what fraction of each period the input spends high. The input goes through a small synchronizer, so every observation below lags the pin by the synchronizer depth.

A rising edge while the block is off powers it up and opens a detection window. A low pulse of qualifying length inside that window selects single-wire command mode at once. Without such a pulse the block settles into pulse-width dimming, which is the default. The mode is then held until the input stays low long enough to force a shutdown. Every rising edge restarts the shutdown timer, so the low phases of ordinary dimming never power the block down.

While pulse-width dimming is in effect, the block counts high cycles and period cycles between successive rising edges. On each rising edge it publishes the ratio as an unsigned fraction of full scale. All time limits are parameters counted in system clock ticks.

Top module: `cpm_top`

## Requirements
- R1: While reset is asserted, `enable` and `modeWire` are 0, `duty` is all ones (255 for 8 bits), and `brightRst` is 1. `brightRst` drops on the first clock edge after reset is released.
- R2: While off, a rising edge on the synchronized input sets `enable` to 1 and opens a window of WIN_TICKS cycles. Until a mode is chosen, `modeWire` stays 0, which means pulse-width dimming.
- R3: A low phase selects single-wire mode (`modeWire` = 1) if it begins at least DELAY_TICKS cycles after the enabling edge and its count of low cycles exceeds DET_TICKS while the window is still open. The switch takes effect while the input is still low.
- R4: A low phase that begins before DELAY_TICKS, or lasts exactly DET_TICKS cycles, or first exceeds DET_TICKS after the window has closed leaves the block in pulse-width mode.
- R5: Once a mode is chosen it stays fixed. Later low pulses of any length below the shutdown limit do not change `modeWire`.
- R6: A low level that lasts more than SHDN_TICKS consecutive cycles drives `enable` to 0. A low level of SHDN_TICKS cycles or fewer does not, and each rising edge restarts the count.
- R7: Each shutdown produces exactly one `brightRst` pulse, one clock cycle wide, so the brightness setting returns to its full-scale default.
- R8: In pulse-width mode, and in the detection window before a mode is chosen, `duty` takes the value min(2^DUTY_W - 1, floor(H * 2^DUTY_W / P)) at each rising edge. H is the count of high cycles and P the count of cycles since the previous rising edge.
- R9: Each start-up sets `duty` to full scale. In pulse-width mode, an input that stays high for 2*SHDN_TICKS cycles with no rising edge also gives full scale.
- R10: In single-wire mode `duty` keeps its value whatever pulses arrive.
- R11: After a shutdown, the next start-up runs detection again and begins in pulse-width mode, whichever mode was in force before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all time limits count its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlPin | input | 1 | Asynchronous control input (enable, mode select, PWM) |
| enable | output | 1 | 1 while the driver is powered up |
| modeWire | output | 1 | 1 when single-wire command mode is locked, 0 for pulse-width dimming |
| brightRst | output | 1 | One-cycle pulse that returns the brightness setting to full scale |
| duty | output | DUTY_W | Measured high fraction of the last PWM period, all ones = 100 % |

## Verification
The bench builds the block with a 10-cycle delay, a 26-cycle detection limit, a 100-cycle window, a 250-cycle shutdown limit and a two-stage synchronizer. At these sizes a whole start-up, detection and shutdown sequence fits in a few hundred cycles, so the bench can drive single-cycle boundary cases directly. These include a low phase of exactly the detection limit, a qualifying low that straddles the window end, low runs just under and over the shutdown limit, and a one-cycle high pulse in a 40-cycle period. The duty vectors use periods short enough that the exact quotient is easy to predict, including values that must round down.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_DET,
    ST_PWM,
    ST_WIRE
  } pinState_e;

  // observations from the datapath to the control
  typedef struct packed {
    logic pinRise;
    logic winOpen;
    logic detMet;
    logic shdnMet;
  } pinObs_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic winClear;
    logic measEn;
    logic dutyFull;
  } ctlStrobe_t;

endpackage

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int DELAY_TICKS = 1000,
  parameter int DET_TICKS   = 2600,
  parameter int WIN_TICKS   = 10000,
  parameter int SHDN_TICKS  = 25000,
  parameter int DUTY_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  ctlStrobe_t        strobe,
  output pinObs_t           obs,
  output logic [DUTY_W-1:0] duty
);

  localparam int PER_MAX = 2 * SHDN_TICKS;
  localparam int CNT_W   = $clog2(PER_MAX + 1);
  localparam int WIN_W   = $clog2(WIN_TICKS + 1);
  localparam int QW      = CNT_W + DUTY_W;

  localparam logic [WIN_W-1:0]  WIN_LIM   = WIN_W'(WIN_TICKS);
  localparam logic [WIN_W-1:0]  DELAY_LIM = WIN_W'(DELAY_TICKS);
  localparam logic [WIN_W-1:0]  WIN_ONE   = WIN_W'(1);
  localparam logic [CNT_W-1:0]  DET_LIM   = CNT_W'(DET_TICKS);
  localparam logic [CNT_W-1:0]  SHDN_LIM  = CNT_W'(SHDN_TICKS);
  localparam logic [CNT_W-1:0]  LOW_CAP   = CNT_W'(SHDN_TICKS + 1);
  localparam logic [CNT_W-1:0]  PER_LIM   = CNT_W'(PER_MAX);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [DUTY_W-1:0] DUTY_FULL = {DUTY_W{1'b1}};

  // input synchronizer, depth picked by parameter
  logic pinNow;
  logic pinPrev;

  generate
    if (SYNC_STAGES <= 1) begin : gSyncOne
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= pinIn;
      end
      assign pinNow = syncQ;
    end else begin : gSyncChain
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
      assign pinNow = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinNow;
  end

  logic pinRise, pinFall;
  assign pinRise = pinNow & ~pinPrev;
  assign pinFall = ~pinNow & pinPrev;

  // detection window counter
  logic [WIN_W-1:0] winCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                winCnt <= WIN_LIM;
    else if (strobe.winClear) winCnt <= '0;
    else if (winCnt < WIN_LIM) winCnt <= winCnt + WIN_ONE;
  end

  logic delayDone;
  assign delayDone = (winCnt >= DELAY_LIM);

  // consecutive low counter, cleared by any high sample
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (pinNow)          lowCnt <= '0;
    else if (lowCnt < LOW_CAP) lowCnt <= lowCnt + CNT_ONE;
  end

  // low phase began after the detection delay
  logic lowQual;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowQual <= 1'b0;
    else if (pinRise) lowQual <= 1'b0;
    else if (pinFall) lowQual <= delayDone;
  end

  assign obs.pinRise = pinRise;
  assign obs.winOpen = (winCnt < WIN_LIM);
  assign obs.detMet  = lowQual && (lowCnt > DET_LIM);
  assign obs.shdnMet = (lowCnt > SHDN_LIM);

  // period and high-time counters, restarted on each rising edge
  logic [CNT_W-1:0] perCnt, hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt <= '0;
      hiCnt  <= '0;
    end else if (pinRise) begin
      perCnt <= CNT_ONE;
      hiCnt  <= CNT_ONE;
    end else begin
      if (perCnt < PER_LIM)           perCnt <= perCnt + CNT_ONE;
      if (pinNow && hiCnt < PER_LIM)  hiCnt  <= hiCnt + CNT_ONE;
    end
  end

  // ratio of high time to period, scaled to DUTY_W bits
  logic [QW-1:0]     quot;
  logic [DUTY_W-1:0] dutyCalc;
  always_comb begin
    if (perCnt == '0) quot = '0;
    else              quot = {hiCnt, {DUTY_W{1'b0}}} / {{DUTY_W{1'b0}}, perCnt};
    if (perCnt == '0 || quot[QW-1:DUTY_W] != '0) dutyCalc = DUTY_FULL;
    else                                         dutyCalc = quot[DUTY_W-1:0];
  end

  logic [DUTY_W-1:0] dutyQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          dutyQ <= DUTY_FULL;
    else if (strobe.dutyFull)                           dutyQ <= DUTY_FULL;
    else if (strobe.measEn && pinRise)                  dutyQ <= dutyCalc;
    else if (strobe.measEn && pinNow && perCnt == PER_LIM) dutyQ <= DUTY_FULL;
  end

  assign duty = dutyQ;

  // R10
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.measEn && !strobe.dutyFull) |=> $stable(dutyQ));

  // R9
  duty_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dutyFull |=> (dutyQ == DUTY_FULL));

endmodule

// File: rtl/cpm_control.sv
module cpm_control
  import cpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pinObs_t    obs,
  output ctlStrobe_t strobe,
  output logic       enable,
  output logic       modeWire,
  output logic       brightRst
);

  pinState_e st, stNext;

  always_comb begin
    stNext = st;
    unique case (st)
      ST_OFF:  if (obs.pinRise) stNext = ST_DET;
      ST_DET: begin
        if (obs.shdnMet)                    stNext = ST_OFF;
        else if (obs.detMet && obs.winOpen) stNext = ST_WIRE;
        else if (!obs.winOpen)              stNext = ST_PWM;
      end
      ST_PWM:  if (obs.shdnMet) stNext = ST_OFF;
      ST_WIRE: if (obs.shdnMet) stNext = ST_OFF;
      default: stNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_OFF;
    else       st <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) brightRst <= 1'b1;
    else       brightRst <= (st != ST_OFF) && obs.shdnMet;
  end

  assign strobe.winClear = (st == ST_OFF) && obs.pinRise;
  assign strobe.dutyFull = (st == ST_OFF) && obs.pinRise;
  assign strobe.measEn   = (st == ST_DET) || (st == ST_PWM);

  assign enable   = (st != ST_OFF);
  assign modeWire = (st == ST_WIRE);

  // R5
  wire_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WIRE) |=> (st == ST_WIRE || st == ST_OFF));

  // R5
  pwm_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PWM) |=> (st == ST_PWM || st == ST_OFF));

  // R2
  wake_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_OFF && !obs.pinRise) |=> (st == ST_OFF));

  // R3
  wire_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DET && obs.detMet && obs.winOpen && !obs.shdnMet) |=> (st == ST_WIRE));

  // R6
  shdn_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_OFF && obs.shdnMet) |=> (st == ST_OFF && brightRst));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    brightRst |=> !brightRst);

endmodule

// File: rtl/cpm_top.sv
module cpm_top
  import cpm_pkg::*;
#(
  parameter int DELAY_TICKS = 1000,
  parameter int DET_TICKS   = 2600,
  parameter int WIN_TICKS   = 10000,
  parameter int SHDN_TICKS  = 25000,
  parameter int DUTY_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlPin,
  output logic              enable,
  output logic              modeWire,
  output logic              brightRst,
  output logic [DUTY_W-1:0] duty
);

  pinObs_t    obs;
  ctlStrobe_t strobe;

  cpm_datapath #(
    .DELAY_TICKS (DELAY_TICKS),
    .DET_TICKS   (DET_TICKS),
    .WIN_TICKS   (WIN_TICKS),
    .SHDN_TICKS  (SHDN_TICKS),
    .DUTY_W      (DUTY_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (ctrlPin),
    .strobe (strobe),
    .obs    (obs),
    .duty   (duty)
  );

  cpm_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .obs       (obs),
    .strobe    (strobe),
    .enable    (enable),
    .modeWire  (modeWire),
    .brightRst (brightRst)
  );

endmodule

// File: tb/cpm_top_tb_top.sv
module cpm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DLY  = 10;
  localparam int DET  = 26;
  localparam int WIN  = 100;
  localparam int SHDN = 250;
  localparam int DW   = 8;

  // high cycles, low cycles, expected duty
  localparam int VEC [6][3] = '{
    '{20, 20, 128}, '{30, 10, 192}, '{39, 1, 249},
    '{1, 39, 6},    '{5, 5, 128},   '{10, 30, 64}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinDrv = 1'b0;
  logic enable, modeWire, brightRst;
  logic [DW-1:0] duty;

  int checks = 0;
  int errors = 0;
  int rstPulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpm_top #(
    .DELAY_TICKS (DLY),
    .DET_TICKS   (DET),
    .WIN_TICKS   (WIN),
    .SHDN_TICKS  (SHDN),
    .DUTY_W      (DW),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlPin   (pinDrv),
    .enable    (enable),
    .modeWire  (modeWire),
    .brightRst (brightRst),
    .duty      (duty)
  );

  always @(negedge clk) if (rstN && brightRst) rstPulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    pinDrv = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R1 enable in reset", enable, 0);
    chk("R1 modeWire in reset", modeWire, 0);
    chk("R1 duty in reset", duty, 255);
    chk("R1 brightRst in reset", brightRst, 1);
    rstN = 1'b1;
    hold(0, 3);
    chk("R1 brightRst after release", brightRst, 0);

    // R2 start-up and R9 full scale
    hold(1, 5);
    chk("R2 enable after rise", enable, 1);
    chk("R2 default pwm", modeWire, 0);
    hold(1, 120);
    chk("R9 constant high duty", duty, 255);
    chk("R2 pwm after window", modeWire, 0);

    // R8 duty vectors
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 3; k++) begin
        hold(1, VEC[i][0]);
        hold(0, VEC[i][1]);
      end
      hold(1, 5);
      chk("R8 duty vector", duty, VEC[i][2]);
    end
    hold(1, 520);
    chk("R9 long high duty", duty, 255);

    // R6 shutdown timing and restart, R7 pulse
    p0 = rstPulses;
    hold(0, 240);
    chk("R6 below limit stays on", enable, 1);
    hold(1, 2);
    hold(0, 240);
    chk("R6 timer restarts on rise", enable, 1);
    hold(0, 20);
    chk("R6 shutdown", enable, 0);
    chk("R7 one reset pulse", rstPulses - p0, 1);

    // R3 wire select, immediate
    hold(1, 20);
    hold(0, 35);
    chk("R3 wire selected while low", modeWire, 1);
    chk("R3 still enabled", enable, 1);
    hold(1, 5);
    // R10 duty frozen in wire mode
    for (int k = 0; k < 3; k++) begin
      hold(1, 10);
      hold(0, 30);
    end
    hold(1, 5);
    chk("R10 duty frozen", duty, 255);
    hold(1, 150);
    hold(0, 40);
    chk("R5 wire locked", modeWire, 1);
    hold(1, 5);

    // R11 restart defaults to pwm
    p0 = rstPulses;
    hold(0, 260);
    chk("R11 off", enable, 0);
    chk("R7 pulse from wire mode", rstPulses - p0, 1);
    hold(1, 130);
    chk("R11 pwm after restart", modeWire, 0);
    hold(0, 40);
    chk("R5 pwm locked", modeWire, 0);
    hold(1, 5);

    // R4 low begins before delay
    hold(0, 260);
    hold(1, 3);
    hold(0, 40);
    chk("R4 early low", modeWire, 0);
    hold(1, 120);
    chk("R4 early low after window", modeWire, 0);

    // R4 low of exactly the limit
    hold(0, 260);
    hold(1, 20);
    hold(0, DET);
    hold(1, 120);
    chk("R4 exact limit", modeWire, 0);

    // R4 qualification after window closes
    hold(0, 260);
    hold(1, 85);
    hold(0, 40);
    hold(1, 10);
    chk("R4 late low", modeWire, 0);
    chk("R4 late low enabled", enable, 1);

    finishRun();
  end

endmodule